// File: doc/BRIEF.md
# Whole-Page Hamming Code Generator and Checker

This engine sits beside a NAND flash data bus and watches every data beat of a page transfer, one byte per beat on an 8-bit bus or one word per beat on a 16-bit bus. Over the whole page it builds a single-error-correct, double-error-detect code. The code goes out as two 16-bit words. The first word is the XOR of the `{word index, bit index}` positions of every set data bit. The second word is the first word XORed with the overall data parity replicated across all 16 bits. Together they are the four code bytes that a host stores in the spare area after a write.

On a read, the host streams the page back and then sends the four stored code bytes (two words on a wide bus). The engine XORs the recomputed code with the received code to form a syndrome and classifies it as one of four results:
- no error;
- a single correctable data error, with its word and bit position;
- a single flipped bit inside the code itself;
- an uncorrectable multiple error.

An erased page, whose stored code reads back as all ones, is reported with an all-ones location so the host can recognise it. When the code sits at an offset in the spare area, a gap mode makes the engine ignore beats after the data until a resume strobe arrives.

The controller is a four-state machine:
- `S_DATA` accumulates data beats and moves on when the configured beat count is reached. It goes to `S_CODE` directly, or to `S_WAIT` when gap mode is set.
- `S_WAIT` discards beats until `code_go` arrives, then moves to `S_CODE`.
- `S_CODE` assembles the received code and moves to `S_DONE` on the final code beat.
- `S_DONE` holds the result.

A `page_start` strobe returns the machine to `S_DATA` from any state.

Top module: `hecc_engine`

## Requirements
- R1: After reset or a `page_start` strobe, `err_any`, `err_multi`, `err_code` and `done` are 0 and both parity outputs read 0. `page_start` also captures `cfg_mode`, `cfg_wide` and `cfg_gap` for the page.
- R2: Once all data beats of a page are taken, and until the check completes, `parity_lo` equals the XOR over every set data bit of the 16-bit value `{word index mod 4096, bit index}`, with the word index in bits [15:4] and the bit index in bits [3:0]. `parity_hi` equals `parity_lo` XOR the overall data parity replicated 16 times.
- R3: A page holds `(BASE_BYTES << cfg_mode) >> cfg_wide` data beats. With the default `BASE_BYTES` of 528, modes 0, 1, 2 and 3 give 528, 1056, 2112 and 4224 bytes.
- R4: The code beats follow the data in this order. On a narrow bus there are four bytes on bits [7:0]: `parity_lo` low byte, `parity_lo` high byte, `parity_hi` low byte, `parity_hi` high byte. On a wide bus there are two words: `parity_lo`, then `parity_hi`. `done` is high for exactly one cycle, the cycle after the last code beat is accepted.
- R5: A zero syndrome gives all flags 0 and both parity outputs 0.
- R6: A syndrome whose low and high halves are bitwise complements gives `err_any`=1, `err_multi`=0 and `err_code`=0. `parity_lo` then holds the error position `{word, bit}` and `parity_hi` its complement.
- R7: A syndrome with exactly one of its 32 bits set gives `err_any`=1, `err_code`=1 and `err_multi`=0. The parity outputs hold the syndrome halves.
- R8: Any other nonzero syndrome gives `err_any`=1, `err_multi`=1 and `err_code`=0. The parity outputs hold the syndrome halves.
- R9: If the received code is all ones and the syndrome is nonzero, the result is `err_any`=1, `err_multi`=1 and `parity_lo`=16'hFFFF, which marks an erased page. This check takes precedence over R6 to R8.
- R10: With gap mode captured, beats that arrive after the data and before a `code_go` strobe are ignored.
- R11: After `done`, further beats are ignored and every output holds until the next `page_start`.
- R12: A `page_start` in the same cycle as a beat wins: the beat is discarded, no result is produced, and the next page starts at beat 0.
- R13: On a narrow bus, bits [15:8] of `beat_data` have no effect on the code or on the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_start | input | 1 | Synchronous strobe that clears the engine and captures the configuration |
| cfg_mode | input | 2 | Page size selector |
| cfg_wide | input | 1 | 1 selects a 16-bit bus, 0 an 8-bit bus |
| cfg_gap | input | 1 | 1 makes the engine wait for `code_go` before taking code beats |
| code_go | input | 1 | Resume strobe used in gap mode |
| beat_valid | input | 1 | A data or code beat is present on `beat_data` |
| beat_data | input | 16 | Bus beat; only bits [7:0] are used on a narrow bus |
| parity_lo | output | 16 | First code word, or the error location after a check |
| parity_hi | output | 16 | Second code word, or the high syndrome half after a check |
| err_any | output | 1 | Some error was seen |
| err_multi | output | 1 | Uncorrectable or erased-page result |
| err_code | output | 1 | Single flipped bit inside the code |
| done | output | 1 | One-cycle pulse when a check completes |

## Verification
A new-page strobe can coincide with the final code beat, which would otherwise finish a check. The bench sends all but the last code byte, then raises `page_start` and a corrupted last byte in the same cycle. It requires that `done` stays low, that no error flag appears and that both parity outputs read 0. It then runs a complete clean page to show that the beat counter restarted at zero.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    typedef enum logic [1:0] {
        S_DATA = 2'd0,
        S_WAIT = 2'd1,
        S_CODE = 2'd2,
        S_DONE = 2'd3
    } hecc_state_e;

    typedef struct packed {
        logic any;
        logic multi;
        logic code;
    } hecc_flags_t;

endpackage

// File: rtl/hecc_beat_fold.sv
// Folds one bus beat into the page code: the XOR of {word, bit} over set bits.
module hecc_beat_fold #(
    parameter int DATA_W = 16,
    parameter int WORD_W = 12,
    parameter int BIT_W  = 4
) (
    input  logic [DATA_W-1:0]       beat,
    input  logic                    wide,
    input  logic [WORD_W-1:0]       word_idx,
    output logic [WORD_W+BIT_W-1:0] contrib,
    output logic                    beat_par
);
    logic [DATA_W-1:0] bits;
    logic [BIT_W-1:0]  bit_x;
    logic              odd;

    always_comb begin
        bits = wide ? beat : {{(DATA_W-8){1'b0}}, beat[7:0]};
        bit_x = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (bits[j]) begin
                bit_x = bit_x ^ BIT_W'(j);
            end
        end
        odd      = ^bits;
        contrib  = {({WORD_W{odd}} & word_idx), bit_x};
        beat_par = odd;
    end
endmodule

// File: rtl/hecc_syndrome.sv
// Classifies the syndrome between recomputed and received code words.
module hecc_syndrome
    import hecc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic [POS_W-1:0] calc_odd,
    input  logic [POS_W-1:0] calc_even,
    input  logic [POS_W-1:0] rx_odd,
    input  logic [POS_W-1:0] rx_even,
    output hecc_flags_t      flags,
    output logic [POS_W-1:0] loc,
    output logic [POS_W-1:0] aux
);
    localparam int OW = $clog2(2*POS_W + 1);

    logic [POS_W-1:0]   s0;
    logic [POS_W-1:0]   s1;
    logic [2*POS_W-1:0] sv;
    logic [OW-1:0]      ones;
    logic               blank;

    always_comb begin
        s0    = calc_odd ^ rx_odd;
        s1    = calc_even ^ rx_even;
        sv    = {s1, s0};
        blank = &{rx_even, rx_odd};
        ones  = '0;
        for (int k = 0; k < 2*POS_W; k++) begin
            ones = ones + OW'(sv[k]);
        end
        flags = '0;
        loc   = s0;
        aux   = s1;
        if (sv == '0) begin
            flags = '0;
        end else if (blank) begin
            flags.any   = 1'b1;
            flags.multi = 1'b1;
            loc         = '1;
        end else if ((s0 ^ s1) == '1) begin
            flags.any = 1'b1;
        end else if (ones == OW'(1)) begin
            flags.any  = 1'b1;
            flags.code = 1'b1;
        end else begin
            flags.any   = 1'b1;
            flags.multi = 1'b1;
        end
    end
endmodule

// File: rtl/hecc_engine.sv
module hecc_engine
    import hecc_pkg::*;
#(
    parameter int BASE_BYTES = 528,
    parameter int DATA_W     = 16,
    parameter int WORD_W     = 12,
    parameter int BIT_W      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        page_start,
    input  logic [1:0]  cfg_mode,
    input  logic        cfg_wide,
    input  logic        cfg_gap,
    input  logic        code_go,
    input  logic        beat_valid,
    input  logic [15:0] beat_data,
    output logic [15:0] parity_lo,
    output logic [15:0] parity_hi,
    output logic        err_any,
    output logic        err_multi,
    output logic        err_code,
    output logic        done
);
    localparam int POS_W     = WORD_W + BIT_W;
    localparam int CODE_W    = 2 * POS_W;
    localparam int MAX_BEATS = BASE_BYTES * 8;
    localparam int CNT_W     = $clog2(MAX_BEATS + 1);
    localparam int LANES_N   = CODE_W / 8;
    localparam int LANES_W   = CODE_W / DATA_W;
    localparam int CIDX_W    = $clog2(LANES_N);

    hecc_state_e        state, state_n;
    logic [1:0]         mode_q;
    logic               wide_q;
    logic               gap_q;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   lim;
    logic [POS_W-1:0]   acc;
    logic               par_q;
    logic [CODE_W-1:0]  rx_all, rx_n;
    logic [CIDX_W-1:0]  cidx;
    logic [POS_W-1:0]   res0, res1;
    hecc_flags_t        flags_q;
    logic               done_q;

    logic [POS_W-1:0]   contrib;
    logic               beat_par;
    logic [POS_W-1:0]   calc_even;
    logic               last_data;
    logic               last_code;
    hecc_flags_t        chk_flags;
    logic [POS_W-1:0]   chk_loc, chk_aux;

    hecc_beat_fold #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W),
        .BIT_W  (BIT_W)
    ) u_fold (
        .beat     (beat_data[DATA_W-1:0]),
        .wide     (wide_q),
        .word_idx (WORD_W'(cnt)),
        .contrib  (contrib),
        .beat_par (beat_par)
    );

    always_comb begin
        calc_even = acc ^ {POS_W{par_q}};
        lim       = CNT_W'((BASE_BYTES << mode_q) >> wide_q);
        last_data = (cnt == lim - CNT_W'(1));
        last_code = wide_q ? (cidx == CIDX_W'(LANES_W - 1))
                           : (cidx == CIDX_W'(LANES_N - 1));
        rx_n = rx_all;
        if (wide_q) begin
            rx_n[32'(cidx) * DATA_W +: DATA_W] = beat_data[DATA_W-1:0];
        end else begin
            rx_n[32'(cidx) * 8 +: 8] = beat_data[7:0];
        end
    end

    hecc_syndrome #(
        .POS_W (POS_W)
    ) u_synd (
        .calc_odd  (acc),
        .calc_even (calc_even),
        .rx_odd    (rx_n[POS_W-1:0]),
        .rx_even   (rx_n[CODE_W-1:POS_W]),
        .flags     (chk_flags),
        .loc       (chk_loc),
        .aux       (chk_aux)
    );

    // next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            S_DATA: if (beat_valid && last_data) state_n = gap_q ? S_WAIT : S_CODE;
            S_WAIT: if (code_go) state_n = S_CODE;
            S_CODE: if (beat_valid && last_code) state_n = S_DONE;
            S_DONE: state_n = S_DONE;
            default: state_n = S_DATA;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_DATA;
        end else if (page_start) begin
            state <= S_DATA;
        end else begin
            state <= state_n;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            wide_q  <= 1'b0;
            gap_q   <= 1'b0;
            cnt     <= '0;
            acc     <= '0;
            par_q   <= 1'b0;
            rx_all  <= '0;
            cidx    <= '0;
            res0    <= '0;
            res1    <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
        end else if (page_start) begin
            mode_q  <= cfg_mode;
            wide_q  <= cfg_wide;
            gap_q   <= cfg_gap;
            cnt     <= '0;
            acc     <= '0;
            par_q   <= 1'b0;
            rx_all  <= '0;
            cidx    <= '0;
            res0    <= '0;
            res1    <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_DATA: begin
                    if (beat_valid) begin
                        acc   <= acc ^ contrib;
                        par_q <= par_q ^ beat_par;
                        cnt   <= cnt + CNT_W'(1);
                    end
                end
                S_CODE: begin
                    if (beat_valid) begin
                        rx_all <= rx_n;
                        cidx   <= cidx + CIDX_W'(1);
                        if (last_code) begin
                            res0    <= chk_loc;
                            res1    <= chk_aux;
                            flags_q <= chk_flags;
                            done_q  <= 1'b1;
                        end
                    end
                end
                S_WAIT, S_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        if (state == S_DONE) begin
            parity_lo = res0;
            parity_hi = res1;
        end else begin
            parity_lo = acc;
            parity_hi = calc_even;
        end
        err_any   = flags_q.any;
        err_multi = flags_q.multi;
        err_code  = flags_q.code;
        done      = done_q;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (!err_any && !err_multi && !err_code && !done
                        && parity_lo == '0 && parity_hi == '0)); // R1
    AST_MULTI_HAS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        err_multi |-> err_any); // R8
    AST_CODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        err_code |-> (err_any && !err_multi)); // R7
    AST_SINGLE_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_any && !err_multi && !err_code) |-> (parity_lo == ~parity_hi)); // R6
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && !page_start) |=> ($stable(res0) && $stable(res1)
                                              && $stable(flags_q) && !done)); // R11
    AST_WAIT_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !page_start) |=> ($stable(rx_all) && $stable(acc)
                                              && $stable(cnt))); // R10
endmodule

// File: tb/hecc_engine_bench.sv
module hecc_engine_bench;
    localparam int BASE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_start = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_wide = 1'b0;
    logic        cfg_gap = 1'b0;
    logic        code_go = 1'b0;
    logic        beat_valid = 1'b0;
    logic [15:0] beat_data = '0;
    logic [15:0] parity_lo, parity_hi;
    logic        err_any, err_multi, err_code, done;

    always #5 clk = ~clk;

    hecc_engine #(.BASE_BYTES(BASE)) u_hecc_engine (
        .clk(clk), .rst_n(rst_n), .page_start(page_start),
        .cfg_mode(cfg_mode), .cfg_wide(cfg_wide), .cfg_gap(cfg_gap),
        .code_go(code_go), .beat_valid(beat_valid), .beat_data(beat_data),
        .parity_lo(parity_lo), .parity_hi(parity_hi),
        .err_any(err_any), .err_multi(err_multi), .err_code(err_code),
        .done(done)
    );

    int vectors = 0;
    int miscomp = 0;
    bit finished = 1'b0;
    logic [15:0] pg [64];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbeats(input int mode, input bit wide);
        return (BASE << mode) >> wide;
    endfunction

    task automatic model(input int n, input bit wide, output logic [15:0] o, output logic [15:0] e);
        logic p;
        o = '0;
        p = 1'b0;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < (wide ? 16 : 8); b++)
                if (pg[i][b]) begin
                    o = o ^ 16'((i << 4) | b);
                    p = ~p;
                end
        e = o ^ {16{p}};
    endtask

    task automatic expect_cls(input logic [15:0] s0, input logic [15:0] s1, input bit blank,
                              output logic a, output logic m, output logic c,
                              output logic [15:0] lo, output logic [15:0] hi);
        a = 1'b1; m = 1'b0; c = 1'b0; lo = s0; hi = s1;
        if (s0 == 16'h0 && s1 == 16'h0) a = 1'b0;
        else if (blank) begin m = 1'b1; lo = 16'hFFFF; end
        else if ((s0 ^ s1) == 16'hFFFF) begin end
        else if ($countones({s1, s0}) == 1) c = 1'b1;
        else m = 1'b1;
    endtask

    task automatic begin_page(input int mode, input bit wide, input bit gap);
        @(negedge clk);
        page_start = 1'b1;
        cfg_mode = mode[1:0];
        cfg_wide = wide;
        cfg_gap = gap;
        beat_valid = 1'b0;
        @(negedge clk);
        page_start = 1'b0;
    endtask

    task automatic push(input logic [15:0] d);
        beat_valid = 1'b1;
        beat_data = d;
        @(negedge clk);
        beat_valid = 1'b0;
    endtask

    task automatic push_data(input int n);
        for (int i = 0; i < n; i++) push(pg[i]);
    endtask

    task automatic push_code(input logic [15:0] r0, input logic [15:0] r1, input bit wide);
        if (wide) begin
            push(r0);
            chk("R4 done early", {31'b0, done}, 32'd0);
            push(r1);
        end else begin
            push({8'h00, r0[7:0]});
            push({8'h00, r0[15:8]});
            push({8'h00, r1[7:0]});
            chk("R4 done early", {31'b0, done}, 32'd0);
            push({8'h00, r1[15:8]});
        end
    endtask

    task automatic read_check(input string tag, input int mode, input bit wide, input bit gap,
                              input logic [15:0] r0, input logic [15:0] r1);
        logic [15:0] c0, c1, elo, ehi;
        logic ea, em, ec;
        int n;
        n = nbeats(mode, wide);
        model(n, wide, c0, c1);
        begin_page(mode, wide, gap);
        push_data(n);
        chk({tag, " R2 R3 code"}, {parity_lo, parity_hi}, {c0, c1});
        if (gap) begin
            push(16'hA5A5);
            push(16'h5A5A);
            chk({tag, " R10 gap held"}, {parity_lo, parity_hi}, {c0, c1});
            chk({tag, " R10 no done"}, {31'b0, done}, 32'd0);
            code_go = 1'b1;
            @(negedge clk);
            code_go = 1'b0;
        end
        push_code(r0, r1, wide);
        expect_cls(c0 ^ r0, c1 ^ r1, &{r0, r1}, ea, em, ec, elo, ehi);
        chk({tag, " R4 done"}, {31'b0, done}, 32'd1);
        chk({tag, " flags"}, {29'b0, err_any, err_multi, err_code}, {29'b0, ea, em, ec});
        chk({tag, " result"}, {parity_lo, parity_hi}, {elo, ehi});
        @(negedge clk);
        chk({tag, " R4 pulse"}, {31'b0, done}, 32'd0);
    endtask

    task automatic fill(input int mode, input bit wide);
        for (int i = 0; i < 64; i++)
            pg[i] = wide ? 16'(i * 40503 + mode * 7 + 1) : {8'h00, 8'(i * 29 + mode * 3 + 5)};
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            miscomp++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        logic [15:0] g0, g1, hold;
        repeat (3) @(negedge clk);
        chk("R1 reset flags", {28'b0, err_any, err_multi, err_code, done}, 32'd0);
        chk("R1 reset parity", {parity_lo, parity_hi}, 32'd0);
        rst_n = 1'b1;

        // R2 R3 R5: clean pages in every mode and width
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++) begin
                fill(m, w[0]);
                model(nbeats(m, w[0]), w[0], g0, g1);
                read_check("R5 clean", m, w[0], 1'b0, g0, g1);
            end

        // R6: every single data-bit error, both widths
        for (int w = 0; w < 2; w++) begin
            fill(0, w[0]);
            model(nbeats(0, w[0]), w[0], g0, g1);
            for (int i = 0; i < nbeats(0, w[0]); i++)
                for (int b = 0; b < (w[0] ? 16 : 8); b++) begin
                    pg[i][b] = ~pg[i][b];
                    read_check("R6 single", 0, w[0], 1'b0, g0, g1);
                    chk("R6 location", {16'h0, parity_lo}, {16'h0, 16'((i << 4) | b)});
                    pg[i][b] = ~pg[i][b];
                end
        end

        // R7: every single code-bit error
        for (int w = 0; w < 2; w++) begin
            fill(1, w[0]);
            model(nbeats(1, w[0]), w[0], g0, g1);
            for (int k = 0; k < 32; k++) begin
                logic [31:0] fl;
                fl = 32'h1 << k;
                read_check("R7 code bit", 1, w[0], 1'b0, g0 ^ fl[15:0], g1 ^ fl[31:16]);
                chk("R7 flag", {31'b0, err_code}, 32'd1);
            end
        end

        // R8: all double data errors on a narrow mode-0 page
        fill(0, 1'b0);
        model(nbeats(0, 1'b0), 1'b0, g0, g1);
        for (int p = 0; p < 64; p++)
            for (int q = p + 1; q < 64; q++) begin
                pg[p / 8][p % 8] = ~pg[p / 8][p % 8];
                pg[q / 8][q % 8] = ~pg[q / 8][q % 8];
                read_check("R8 double", 0, 1'b0, 1'b0, g0, g1);
                pg[p / 8][p % 8] = ~pg[p / 8][p % 8];
                pg[q / 8][q % 8] = ~pg[q / 8][q % 8];
            end

        // R9: erased pages
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < 64; i++) pg[i] = w[0] ? 16'hFFFF : 16'h00FF;
            read_check("R9 erased", 0, w[0], 1'b0, 16'hFFFF, 16'hFFFF);
            chk("R9 marker", {15'b0, err_multi, parity_lo}, {15'b0, 1'b1, 16'hFFFF});
        end

        // R10: gap mode ignores beats before code_go
        for (int w = 0; w < 2; w++) begin
            fill(1, w[0]);
            model(nbeats(1, w[0]), w[0], g0, g1);
            read_check("R10 gap", 1, w[0], 1'b1, g0, g1);
        end

        // R11: beats after done are ignored
        fill(0, 1'b0);
        model(nbeats(0, 1'b0), 1'b0, g0, g1);
        pg[3][5] = ~pg[3][5];
        read_check("R11 base", 0, 1'b0, 1'b0, g0, g1);
        hold = parity_lo;
        push(16'h00AA);
        push(16'h0055);
        push(16'h0011);
        chk("R11 hold loc", {16'h0, parity_lo}, {16'h0, hold});
        chk("R11 hold flags", {28'b0, err_any, err_multi, err_code, done}, 32'b1000);
        pg[3][5] = ~pg[3][5];

        // R12: page_start together with the final code beat
        fill(0, 1'b0);
        model(nbeats(0, 1'b0), 1'b0, g0, g1);
        begin_page(0, 1'b0, 1'b0);
        push_data(nbeats(0, 1'b0));
        push({8'h00, g0[7:0]});
        push({8'h00, g0[15:8]});
        push({8'h00, g1[7:0]});
        page_start = 1'b1;
        beat_valid = 1'b1;
        beat_data = {8'h00, ~g1[15:8]};
        @(negedge clk);
        page_start = 1'b0;
        beat_valid = 1'b0;
        chk("R12 no done", {28'b0, err_any, err_multi, err_code, done}, 32'd0);
        chk("R12 cleared", {parity_lo, parity_hi}, 32'd0);
        push_data(nbeats(0, 1'b0));
        chk("R12 restart code", {parity_lo, parity_hi}, {g0, g1});
        push_code(g0, g1, 1'b0);
        chk("R12 restart clean", {28'b0, err_any, err_multi, err_code, done}, 32'd1);
        @(negedge clk);

        // R13: upper byte ignored on a narrow bus
        fill(2, 1'b0);
        model(nbeats(2, 1'b0), 1'b0, g0, g1);
        for (int i = 0; i < 64; i++) pg[i][15:8] = 8'(i * 13 + 7);
        read_check("R13 upper", 2, 1'b0, 1'b0, g0, g1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule